// File: doc/BRIEF.md
# Programmable Johnson Clock Divider

This block divides its clock by a selectable ratio N anywhere from 3 to 10, using a five-stage twisted-ring shift register. The divided waveform is the value about to enter the first stage (the ring's data node). It is symmetric for even N and one cycle short of symmetric for odd N. The ratio is set by choosing which stage feeds back, inverted, into the first stage. For odd ratios an extra gate combines two neighbouring stages, so that one state of the sequence is skipped.

The ring corrects itself. When the stages that take part in the loop for the chosen ratio hold a pattern that a twisted ring can never reach by counting, the next clock clears the ring. Counting then resumes from the all-zero state.

A preset path loads a five-bit word into the stages. While preset is held, the inverted stage outputs follow that word without waiting for a clock edge, so the block can also be used as a five-bit transparent latch. Control pins are plain levels. The block has no streamed data interface, so there is no valid/ready handshake and no back-pressure.

Top module: `johnson_divn`

## Requirements
- R1: When `rst` is high at a rising clock edge, all stages are cleared. Afterwards `stage_n_o` reads 5'b11111 and `div_o` reads 1.
- R2: Reset has priority over preset. With `rst` and `preset_en` both high, the stages still clear, and `stage_n_o` shows the inverted stored stages rather than the jam word.
- R3: While `preset_en` is high and `rst` is low, `stage_n_o` equals `~jam_i` in the same cycle. At each rising edge the stages store `jam_i`, with bit 0 being stage 1.
- R4: Preset has priority over counting and over correction. Any jam word, including one that is not a legal ring state, is stored unchanged.
- R5: For an even ratio N = 2k, `div_o` is the inverse of stage k. Starting from the cleared state, `div_o` repeats every N cycles and is high for k cycles of each period.
- R6: For an odd ratio N = 2k-1, `div_o` is the NOR of stages k and k-1. Starting from the cleared state, `div_o` repeats every N cycles and is high for k-1 cycles of each period.
- R7: `n_sel_i` values below 3 behave as 3, and values above 10 behave as 10.
- R8: A state is illegal when its first k stages (k = ceil(N/2)) contain more than one change between neighbouring stages. When counting and the state is illegal, the next edge clears the ring. From any of the 32 states, the active stages hold a legal pattern after N counting edges.
- R9: When counting with a legal state, each edge shifts the ring: stage 1 takes the value `div_o` had before the edge, and stage i takes the value of stage i-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock to be divided |
| rst | input | 1 | Synchronous clear, active high |
| preset_en | input | 1 | Load/latch enable, active high |
| jam_i | input | 5 | Word loaded into the stages (bit 0 = stage 1) |
| n_sel_i | input | 4 | Division ratio, clamped to 3..10 |
| stage_n_o | output | 5 | Inverted stage values (transparent jam word during preset) |
| div_o | output | 1 | Divided clock taken from the ring's data node |

## Verification
Reset and preset can be asserted in the same cycle. The bench drives both with a nonzero jam word and checks that the stages still clear and that the outputs do not show the jam word. Preset and self-correction can also meet: every illegal pattern is jammed in while preset is high, and the bench checks that the pattern is stored untouched. The cycle after preset is released, the bench checks that the ring clears. Every cycle is compared against a behavioural model. For each ratio, the bench also measures the duty cycle and the period of `div_o`.

// File: rtl/johnson_divn_pkg.sv
package johnson_divn_pkg;
  localparam int NMIN = 3;

  typedef enum logic [1:0] {
    MODE_CLEAR = 2'd0,
    MODE_LOAD  = 2'd1,
    MODE_FIX   = 2'd2,
    MODE_COUNT = 2'd3
  } ring_mode_e;
endpackage

// File: rtl/jdn_sel.sv
module jdn_sel #(
  parameter int STAGES = 5,
  parameter int SEL_W  = 4
) (
  input  logic [SEL_W-1:0] n_sel_i,
  output logic [SEL_W-1:0] n_eff_o
);
  import johnson_divn_pkg::*;
  localparam logic [SEL_W-1:0] LO = SEL_W'(NMIN);
  localparam logic [SEL_W-1:0] HI = SEL_W'(2 * STAGES);

  always_comb begin
    if (n_sel_i < LO)      n_eff_o = LO;
    else if (n_sel_i > HI) n_eff_o = HI;
    else                   n_eff_o = n_sel_i;
  end
endmodule

// File: rtl/jdn_tap.sv
module jdn_tap #(
  parameter int STAGES = 5,
  parameter int SEL_W  = 4
) (
  input  logic [STAGES-1:0] ring_i,
  input  logic [SEL_W-1:0]  n_eff_i,
  output logic              data_o
);
  logic [STAGES:0]  even_fb;
  logic [STAGES:0]  odd_fb;
  logic [SEL_W-1:0] half;

  assign even_fb[1:0] = '0;
  assign odd_fb[1:0]  = '0;

  for (genvar k = 2; k <= STAGES; k++) begin : g_tap
    assign even_fb[k] = ~ring_i[k-1];
    assign odd_fb[k]  = ~(ring_i[k-1] | ring_i[k-2]);
  end

  always_comb begin
    half   = SEL_W'((n_eff_i + SEL_W'(1)) >> 1);
    data_o = n_eff_i[0] ? odd_fb[int'(half)] : even_fb[int'(half)];
  end
endmodule

// File: rtl/jdn_guard.sv
module jdn_guard #(
  parameter int STAGES = 5,
  parameter int SEL_W  = 4
) (
  input  logic [STAGES-1:0] ring_i,
  input  logic [SEL_W-1:0]  n_eff_i,
  output logic              ok_o
);
  logic [STAGES-2:0] edges;
  logic [STAGES-2:0] mask;
  logic [STAGES-2:0] hit;
  logic [SEL_W-1:0]  half;

  assign edges = ring_i[STAGES-1:1] ^ ring_i[STAGES-2:0];

  always_comb begin
    half = SEL_W'((n_eff_i + SEL_W'(1)) >> 1);
    for (int j = 0; j < STAGES - 1; j++) mask[j] = (j + 1 < int'(half));
    hit  = edges & mask;
    ok_o = ((hit & (hit - 1'b1)) == '0);
  end
endmodule

// File: rtl/johnson_divn.sv
module johnson_divn #(
  parameter int STAGES = 5,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              preset_en,
  input  logic [STAGES-1:0] jam_i,
  input  logic [SEL_W-1:0]  n_sel_i,
  output logic [STAGES-1:0] stage_n_o,
  output logic              div_o
);
  import johnson_divn_pkg::*;

  logic [STAGES-1:0] ring_q;
  logic [STAGES-1:0] ring_d;
  logic [SEL_W-1:0]  n_eff;
  logic              data_node;
  logic              ring_ok;
  ring_mode_e        mode;

  jdn_sel #(.STAGES(STAGES), .SEL_W(SEL_W)) u_sel (
    .n_sel_i (n_sel_i),
    .n_eff_o (n_eff)
  );

  jdn_tap #(.STAGES(STAGES), .SEL_W(SEL_W)) u_tap (
    .ring_i  (ring_q),
    .n_eff_i (n_eff),
    .data_o  (data_node)
  );

  jdn_guard #(.STAGES(STAGES), .SEL_W(SEL_W)) u_guard (
    .ring_i  (ring_q),
    .n_eff_i (n_eff),
    .ok_o    (ring_ok)
  );

  always_comb begin
    if (rst)            mode = MODE_CLEAR;
    else if (preset_en) mode = MODE_LOAD;
    else if (!ring_ok)  mode = MODE_FIX;
    else                mode = MODE_COUNT;
  end

  always_comb begin
    unique case (mode)
      MODE_LOAD:  ring_d = jam_i;
      MODE_COUNT: ring_d = {ring_q[STAGES-2:0], data_node};
      default:    ring_d = '0;
    endcase
  end

  always_ff @(posedge clk) ring_q <= ring_d;

  assign stage_n_o = (preset_en && !rst) ? ~jam_i : ~ring_q;
  assign div_o     = data_node;

  // R1 / R2: reset clears the ring whatever preset does
  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (1'b0)
    rst |=> (ring_q == '0));

  // R3 / R4: preset stores the jam word untouched
  assert_preset_loads_R3: assert property (@(posedge clk) disable iff (rst)
    preset_en |=> (ring_q == $past(jam_i)));

  // R8: when not loading with a steady ratio, the next state is always legal
  assert_ring_legal_R8: assert property (@(posedge clk) disable iff (rst)
    (!preset_en ##1 $stable(n_sel_i)) |-> ring_ok);

  // R9: legal counting shifts the data node into stage 1
  assert_ring_shift_R9: assert property (@(posedge clk) disable iff (rst)
    (!preset_en && ring_ok) |=>
      (ring_q[0] == $past(div_o)) && (ring_q[STAGES-1:1] == $past(ring_q[STAGES-2:0])));

  // R7: the effective ratio always lies in the supported range
  always_comb begin
    if (!$isunknown(n_sel_i))
      assert_ratio_range_R7: assert (n_eff >= SEL_W'(NMIN) && n_eff <= SEL_W'(2 * STAGES));
  end
endmodule

// File: tb/johnson_divn_bench.sv
module johnson_divn_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       preset_en = 1'b0;
  logic [4:0] jam_i = '0;
  logic [3:0] n_sel_i = 4'd4;
  logic [4:0] stage_n_o;
  logic       div_o;

  int checks = 0;
  int errors = 0;
  logic [4:0] m = '0;

  always #2 clk = ~clk;

  johnson_divn u_johnson_divn (
    .clk(clk), .rst(rst), .preset_en(preset_en), .jam_i(jam_i),
    .n_sel_i(n_sel_i), .stage_n_o(stage_n_o), .div_o(div_o)
  );

  function automatic int neff(input int n);
    return (n < 3) ? 3 : (n > 10) ? 10 : n;
  endfunction

  function automatic bit legal(input logic [4:0] s, input int n);
    int k = (neff(n) + 1) / 2;
    int flips = 0;
    for (int j = 0; j + 1 < k; j++) if (s[j] != s[j+1]) flips++;
    return flips <= 1;
  endfunction

  function automatic logic dnode(input logic [4:0] s, input int n);
    int e = neff(n);
    int k = (e + 1) / 2;
    if (e % 2 == 0) return !s[k-1];
    return !(s[k-1] | s[k-2]);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // one clock: drive, compare against the model, then advance the model
  task automatic tick(input logic r, input logic p, input logic [4:0] j,
                      input logic [3:0] n, input bit cmp, input string req);
    logic [4:0] eq;
    logic [4:0] nxt;
    logic       ed;
    @(negedge clk);
    rst = r; preset_en = p; jam_i = j; n_sel_i = n;
    #1;
    eq = (p && !r) ? ~j : ~m;
    ed = dnode(m, int'(n));
    if (cmp) begin
      check(stage_n_o === eq, {req, " stages"}, int'(stage_n_o), int'(eq));
      check(div_o === ed, {req, " div"}, int'(div_o), int'(ed));
    end
    if (r)                   nxt = '0;
    else if (p)              nxt = j;
    else if (!legal(m, n))   nxt = '0;
    else                     nxt = {m[3:0], ed};
    @(posedge clk);
    m = nxt;
  endtask

  task automatic run_ratio(input logic [3:0] n, input string req);
    logic seen [$];
    int   e = neff(int'(n));
    int   highs = 0;
    int   expect_hi = (e % 2 == 0) ? e : e - 1;
    bit   per_ok = 1'b1;
    tick(1'b1, 1'b0, 5'd0, n, 1'b1, "R1");
    for (int t = 0; t < 2 * e; t++) begin
      tick(1'b0, 1'b0, 5'd0, n, 1'b1, "R9");
      seen.push_back(div_o);
      if (div_o) highs++;
    end
    for (int t = 0; t < e; t++) if (seen[t] !== seen[t+e]) per_ok = 1'b0;
    check(highs == expect_hi, {req, " duty"}, highs, expect_hi);
    check(per_ok && seen[0] === 1'b1, {req, " period"}, int'(per_ok), 1);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    tick(1'b1, 1'b0, 5'd0, 4'd4, 1'b0, "R1");
    // R2: reset and preset together; reset wins, jam word not shown
    tick(1'b1, 1'b1, 5'b10101, 4'd4, 1'b1, "R2");
    tick(1'b0, 1'b0, 5'd0, 4'd4, 1'b0, "R2");
    check(stage_n_o === 5'b11111, "R1 cleared", int'(stage_n_o), 5'h1f);
    check(div_o === 1'b1, "R1 div after clear", int'(div_o), 1);

    // R5 even ratios, R6 odd ratios
    for (int n = 3; n <= 10; n++) run_ratio(4'(n), (n % 2 == 0) ? "R5" : "R6");
    // R7 clamping of out-of-range selections
    for (int n = 0; n <= 15; n++) if (n < 3 || n > 10) run_ratio(4'(n), "R7");

    // R3 transparent latch with the clock ignored
    for (int v = 0; v < 32; v += 5) tick(1'b0, 1'b1, 5'(v), 4'd10, 1'b1, "R3");
    check(stage_n_o === ~5'd30, "R3 latch follow", int'(stage_n_o), int'(~5'd30));

    // R4 / R8: jam every pattern, then count and require a legal window
    for (int n = 3; n <= 10; n++) begin
      for (int s = 0; s < 32; s++) begin
        tick(1'b0, 1'b1, 5'(s), 4'(n), 1'b1, "R4");
        for (int t = 0; t < n; t++) tick(1'b0, 1'b0, 5'd0, 4'(n), 1'b1, "R8");
        #1;
        check(legal(~stage_n_o, n), "R8 legal window", int'(stage_n_o), s);
      end
    end
    finish_up();
  end
endmodule